// File: doc/BRIEF.md
# Paged Packet Buffer Allocator

This block manages a packet memory carved into 256-byte pages on behalf of an Ethernet controller. Software issues commands through one command port. It can allocate a run of contiguous pages, release the packet at the head of the receive queue, free a chosen packet, queue a chosen packet for transmission, or wipe the whole pool. An allocation completes asynchronously. The result register shows a failure bit until a packet number can be granted, and a sticky interrupt flag is raised when the grant lands. The request stays pending for as long as no free run of pages is large enough.

Three queues of packet numbers are kept: receive, transmit and transmit-done. The transmitter reports completion of the packet at the head of the transmit queue. With automatic release on, a packet sent without error returns its pages to the pool at once and is not reported. Every other completed packet goes to the transmit-done queue. The memory data path and the MAC are not part of this block.

Top module: `pkt_page_alloc`

## Requirements
- R1: After reset, busy is 0, the allocation result reads 0x80, the interrupt flag is 0 and the receive, transmit and transmit-done queues all read empty.
- R2: An allocate command (opcode 1) sets the result to 0x80 (bit 7 = fail) at the next edge. On the edge after that, if the request fits, the result becomes {0, packet number} with bit 7 clear and the interrupt flag is set. The granted number is the lowest number not in use.
- R3: The page field of an allocate command holds the page count minus one. A request is granted only when that many contiguous pages are free, and the lowest fitting start page is used. The pool holds 18 pages.
- R4: An allocation that does not fit stays pending, with the result at 0x80, until pages are freed. A new allocate command replaces a pending request.
- R5: Reset (opcode 2), receive release (opcode 3) and free (opcode 4) hold busy high for exactly two sampled cycles. Any command presented while busy is high is ignored.
- R6: The reset command frees every page and packet number, empties all three queues, cancels any pending request, sets the result to 0x80 and clears the interrupt flag.
- R7: The free command returns the pages of the packet on the select input. Freeing a packet number that is not allocated changes nothing.
- R8: The enqueue command (opcode 5) appends the select input to the transmit queue. Packets leave the queue in the order they were enqueued.
- R9: On a transmit completion, the head of the transmit queue is removed. If the completion reports success and automatic release is on, its pages are freed and nothing is posted. Otherwise its number is appended to the transmit-done queue and its pages stay in use.
- R10: Packet numbers pushed by the receiver form a first-in first-out queue. A receive release removes the head and frees its pages.
- R11: The interrupt flag stays set until an acknowledge arrives. A grant in the same cycle as an acknowledge leaves the flag set.
- R12: A free command and an automatic release of a different packet in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | Command opcode (0 none, 1 allocate, 2 reset, 3 receive release, 4 free, 5 enqueue) |
| cmdPages | input | 3 | Allocate page count minus one |
| selPkt | input | 4 | Selected packet number for free and enqueue |
| autoRelease | input | 1 | Free successfully sent packets without reporting them |
| irqAck | input | 1 | Clears the allocation interrupt flag |
| rxPush | input | 1 | Receiver appends a packet number |
| rxPkt | input | 4 | Packet number from the receiver |
| txDone | input | 1 | Transmitter finished the head packet |
| txOk | input | 1 | Transmission succeeded |
| txDonePop | input | 1 | Removes the head of the transmit-done queue |
| busy | output | 1 | A command is executing |
| allocResult | output | 8 | Bit 7 fail, low bits granted packet number |
| allocIrq | output | 1 | Allocation-complete interrupt flag |
| rxEmpty | output | 1 | Receive queue empty |
| rxHead | output | 4 | Head of the receive queue |
| txQEmpty | output | 1 | Transmit queue empty |
| txQHead | output | 4 | Packet currently being transmitted |
| txDoneEmpty | output | 1 | Transmit-done queue empty |
| txDoneHead | output | 4 | Head of the transmit-done queue |

## Verification
Two events can free pages in the same cycle: a software free command and an automatic release from a successful transmission. The bench drives both on one edge for two different packets in a full pool. It then shows that each freed run can be granted again, and that a missing release would leave an allocation stuck at 0x80. It also lands an interrupt acknowledge on the edge where a pending grant completes, and requires the flag to remain set.

// File: rtl/pba_pkg.sv
package pba_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_ALLOC = 3'd1,
    OP_RESET = 3'd2,
    OP_RXREL = 3'd3,
    OP_FREE  = 3'd4,
    OP_ENQ   = 3'd5
  } cmdOp_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic doReset;
    logic doGrant;
    logic doFreeSel;
    logic doRxRelease;
    logic doEnqueue;
  } strobes_t;

endpackage

// File: rtl/pba_fifo.sv
module pba_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] count;
  logic          full, doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign doPop  = pop && !empty;
  assign doPush = push && (!full || doPop);
  assign head   = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clear) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= pushData;
        wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (doPop) rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  p_fifo_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

endmodule

// File: rtl/pba_ctrl.sv
module pba_ctrl
  import pba_pkg::*;
#(
  parameter int CNT_W    = 3,
  parameter int PKT_W    = 4,
  parameter int RES_W    = 8,
  parameter int BUSY_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [CNT_W-1:0] cmdPages,
  input  logic             irqAck,
  input  logic             grantOk,
  input  logic [PKT_W-1:0] grantPkt,
  output strobes_t         strb,
  output logic [CNT_W-1:0] reqPages,
  output logic             busy,
  output logic [RES_W-1:0] allocResult,
  output logic             allocIrq
);
  localparam int BW = $clog2(BUSY_CYC + 1);
  localparam logic [RES_W-1:0] FAIL_VAL = {1'b1, {(RES_W-1){1'b0}}};

  logic [BW-1:0] busyCnt;
  logic          pendQ;
  logic          accept, isAlloc;
  cmdOp_e        op;

  assign op      = cmdOp_e'(cmdOp);
  assign accept  = cmdValid && (busyCnt == '0);
  assign isAlloc = accept && (op == OP_ALLOC);
  assign busy    = (busyCnt != '0);

  always_comb begin
    strb.doReset     = accept && (op == OP_RESET);
    strb.doFreeSel   = accept && (op == OP_FREE);
    strb.doRxRelease = accept && (op == OP_RXREL);
    strb.doEnqueue   = accept && (op == OP_ENQ);
    // reset and a fresh request both override a grant of the old request
    strb.doGrant     = pendQ && grantOk && !strb.doReset && !isAlloc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt     <= '0;
      pendQ       <= 1'b0;
      reqPages    <= '0;
      allocResult <= FAIL_VAL;
      allocIrq    <= 1'b0;
    end else begin
      if (strb.doReset || strb.doFreeSel || strb.doRxRelease)
        busyCnt <= BW'(BUSY_CYC);
      else if (busyCnt != '0)
        busyCnt <= busyCnt - 1'b1;

      if (strb.doReset) begin
        pendQ       <= 1'b0;
        allocResult <= FAIL_VAL;
      end else if (isAlloc) begin
        pendQ       <= 1'b1;
        reqPages    <= cmdPages;
        allocResult <= FAIL_VAL;
      end else if (strb.doGrant) begin
        pendQ       <= 1'b0;
        allocResult <= {{(RES_W-PKT_W){1'b0}}, grantPkt};
      end

      if (strb.doReset)      allocIrq <= 1'b0;
      else if (strb.doGrant) allocIrq <= 1'b1;
      else if (irqAck)       allocIrq <= 1'b0;
    end
  end

  p_busy_min_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy);

  p_alloc_fail_r2: assert property (@(posedge clk) disable iff (!rstN)
    isAlloc |=> (allocResult[RES_W-1] && !allocIrq) || $past(allocIrq));

  p_grant_result_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.doGrant |=> (!allocResult[RES_W-1] && allocIrq));

  p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    (allocIrq && !irqAck && !strb.doReset) |=> allocIrq);

endmodule

// File: rtl/pba_dp.sv
module pba_dp
  import pba_pkg::*;
#(
  parameter int NUM_PAGES = 18,
  parameter int NUM_PKTS  = 16,
  parameter int CNT_W     = 3,
  parameter int PKT_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strb,
  input  logic [CNT_W-1:0] reqPages,
  input  logic [PKT_W-1:0] selPkt,
  input  logic             autoRelease,
  input  logic             rxPush,
  input  logic [PKT_W-1:0] rxPkt,
  input  logic             txDone,
  input  logic             txOk,
  input  logic             txDonePop,
  output logic             grantOk,
  output logic [PKT_W-1:0] grantPkt,
  output logic             rxEmpty,
  output logic [PKT_W-1:0] rxHead,
  output logic             txQEmpty,
  output logic [PKT_W-1:0] txQHead,
  output logic             txDoneEmpty,
  output logic [PKT_W-1:0] txDoneHead
);
  localparam int PIDX_W = $clog2(NUM_PAGES);

  logic [NUM_PAGES-1:0] pageUsed;
  logic [NUM_PKTS-1:0]  pktValid;
  logic [PIDX_W-1:0]    pktBase [NUM_PKTS];
  logic [CNT_W-1:0]     pktCnt  [NUM_PKTS];

  function automatic logic [NUM_PAGES-1:0] spanMask(input int base, input int cnt);
    logic [NUM_PAGES-1:0] m;
    for (int i = 0; i < NUM_PAGES; i++) m[i] = (i >= base) && (i <= base + cnt);
    return m;
  endfunction

  // lowest start page whose run is entirely free
  logic                 fitFound, pktFound;
  int                   fitBase;
  logic [NUM_PAGES-1:0] grantMask;
  always_comb begin
    fitFound = 1'b0;
    fitBase  = 0;
    for (int b = NUM_PAGES - 1; b >= 0; b--) begin
      if ((b + int'(reqPages) <= NUM_PAGES - 1) &&
          ((pageUsed & spanMask(b, int'(reqPages))) == '0)) begin
        fitFound = 1'b1;
        fitBase  = b;
      end
    end
    pktFound = 1'b0;
    grantPkt = '0;
    for (int p = NUM_PKTS - 1; p >= 0; p--) begin
      if (!pktValid[p]) begin
        pktFound = 1'b1;
        grantPkt = PKT_W'(p);
      end
    end
    grantMask = spanMask(fitBase, int'(reqPages));
  end
  assign grantOk = fitFound && pktFound;

  // two release sources: a software command and an automatic release
  logic             cmdFreeEn, autoFreeEn, donePush;
  logic [PKT_W-1:0] cmdFreePkt, autoFreePkt;
  logic [NUM_PAGES-1:0] freeMaskA, freeMaskB;

  assign cmdFreePkt  = strb.doFreeSel ? selPkt : rxHead;
  assign cmdFreeEn   = strb.doFreeSel || (strb.doRxRelease && !rxEmpty);
  assign autoFreePkt = txQHead;
  assign autoFreeEn  = txDone && !txQEmpty && txOk && autoRelease;
  assign donePush    = txDone && !txQEmpty && !(txOk && autoRelease);

  assign freeMaskA = (cmdFreeEn && pktValid[cmdFreePkt]) ?
                     spanMask(int'(pktBase[cmdFreePkt]), int'(pktCnt[cmdFreePkt])) : '0;
  assign freeMaskB = (autoFreeEn && pktValid[autoFreePkt]) ?
                     spanMask(int'(pktBase[autoFreePkt]), int'(pktCnt[autoFreePkt])) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageUsed <= '0;
      pktValid <= '0;
      for (int p = 0; p < NUM_PKTS; p++) begin
        pktBase[p] <= '0;
        pktCnt[p]  <= '0;
      end
    end else if (strb.doReset) begin
      pageUsed <= '0;
      pktValid <= '0;
    end else begin
      pageUsed <= (pageUsed & ~freeMaskA & ~freeMaskB) |
                  (strb.doGrant ? grantMask : '0);
      for (int p = 0; p < NUM_PKTS; p++) begin
        if ((cmdFreeEn && cmdFreePkt == PKT_W'(p)) ||
            (autoFreeEn && autoFreePkt == PKT_W'(p)))
          pktValid[p] <= 1'b0;
      end
      if (strb.doGrant) begin
        pktValid[grantPkt] <= 1'b1;
        pktBase[grantPkt]  <= PIDX_W'(fitBase);
        pktCnt[grantPkt]   <= reqPages;
      end
    end
  end

  pba_fifo #(.DEPTH(NUM_PKTS), .W(PKT_W)) u_rxFifo (
    .clk(clk), .rstN(rstN), .clear(strb.doReset),
    .push(rxPush), .pushData(rxPkt), .pop(strb.doRxRelease),
    .head(rxHead), .empty(rxEmpty));

  pba_fifo #(.DEPTH(NUM_PKTS), .W(PKT_W)) u_txFifo (
    .clk(clk), .rstN(rstN), .clear(strb.doReset),
    .push(strb.doEnqueue), .pushData(selPkt), .pop(txDone),
    .head(txQHead), .empty(txQEmpty));

  pba_fifo #(.DEPTH(NUM_PKTS), .W(PKT_W)) u_doneFifo (
    .clk(clk), .rstN(rstN), .clear(strb.doReset),
    .push(donePush), .pushData(txQHead), .pop(txDonePop),
    .head(txDoneHead), .empty(txDoneEmpty));

  p_grant_pages_free_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.doGrant |-> ((pageUsed & grantMask) == '0));

  p_grant_new_pkt_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.doGrant |-> !pktValid[grantPkt]);

  p_reset_all_free_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.doReset |=> (pageUsed == '0 && pktValid == '0));

  p_auto_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    autoFreeEn |=> !pktValid[$past(autoFreePkt)]);

endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
  import pba_pkg::*;
#(
  parameter int NUM_PAGES = 18,
  parameter int NUM_PKTS  = 16,
  parameter int CNT_W     = 3,
  parameter int RES_W     = 8,
  parameter int BUSY_CYC  = 2,
  localparam int PKT_W    = $clog2(NUM_PKTS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [CNT_W-1:0] cmdPages,
  input  logic [PKT_W-1:0] selPkt,
  input  logic             autoRelease,
  input  logic             irqAck,
  input  logic             rxPush,
  input  logic [PKT_W-1:0] rxPkt,
  input  logic             txDone,
  input  logic             txOk,
  input  logic             txDonePop,
  output logic             busy,
  output logic [RES_W-1:0] allocResult,
  output logic             allocIrq,
  output logic             rxEmpty,
  output logic [PKT_W-1:0] rxHead,
  output logic             txQEmpty,
  output logic [PKT_W-1:0] txQHead,
  output logic             txDoneEmpty,
  output logic [PKT_W-1:0] txDoneHead
);
  strobes_t         strb;
  logic [CNT_W-1:0] reqPages;
  logic             grantOk;
  logic [PKT_W-1:0] grantPkt;

  pba_ctrl #(.CNT_W(CNT_W), .PKT_W(PKT_W), .RES_W(RES_W), .BUSY_CYC(BUSY_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdPages(cmdPages), .irqAck(irqAck), .grantOk(grantOk),
    .grantPkt(grantPkt), .strb(strb), .reqPages(reqPages), .busy(busy),
    .allocResult(allocResult), .allocIrq(allocIrq));

  pba_dp #(.NUM_PAGES(NUM_PAGES), .NUM_PKTS(NUM_PKTS), .CNT_W(CNT_W), .PKT_W(PKT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqPages(reqPages),
    .selPkt(selPkt), .autoRelease(autoRelease), .rxPush(rxPush),
    .rxPkt(rxPkt), .txDone(txDone), .txOk(txOk), .txDonePop(txDonePop),
    .grantOk(grantOk), .grantPkt(grantPkt), .rxEmpty(rxEmpty),
    .rxHead(rxHead), .txQEmpty(txQEmpty), .txQHead(txQHead),
    .txDoneEmpty(txDoneEmpty), .txDoneHead(txDoneHead));

endmodule

// File: tb/pkt_page_alloc_bench.sv
module pkt_page_alloc_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [2:0] cmdPages = 3'd0;
  logic [3:0] selPkt = 4'd0;
  logic       autoRelease = 1'b0;
  logic       irqAck = 1'b0;
  logic       rxPush = 1'b0;
  logic [3:0] rxPkt = 4'd0;
  logic       txDone = 1'b0;
  logic       txOk = 1'b0;
  logic       txDonePop = 1'b0;
  logic       busy, allocIrq, rxEmpty, txQEmpty, txDoneEmpty;
  logic [7:0] allocResult;
  logic [3:0] rxHead, txQHead, txDoneHead;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  localparam logic [2:0] ALLOC = 3'd1, RESET = 3'd2, RXREL = 3'd3, FREE = 3'd4, ENQ = 3'd5;

  always #10 clk = ~clk;

  pkt_page_alloc u_pkt_page_alloc (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdPages(cmdPages), .selPkt(selPkt), .autoRelease(autoRelease),
    .irqAck(irqAck), .rxPush(rxPush), .rxPkt(rxPkt), .txDone(txDone),
    .txOk(txOk), .txDonePop(txDonePop), .busy(busy),
    .allocResult(allocResult), .allocIrq(allocIrq), .rxEmpty(rxEmpty),
    .rxHead(rxHead), .txQEmpty(txQEmpty), .txQHead(txQHead),
    .txDoneEmpty(txDoneEmpty), .txDoneHead(txDoneHead));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [2:0] pg, input logic [3:0] sel);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdPages = pg; selPkt = sel;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic ackIrq();
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
  endtask

  task automatic wipe();
    issue(RESET, 3'd0, 4'd0);
    waitIdle();
  endtask

  task automatic freePkt(input logic [3:0] p);
    issue(FREE, 3'd0, p);
    waitIdle();
  endtask

  task automatic allocGrant(input logic [2:0] pg, input logic [3:0] pkt, input string tag);
    ackIrq();
    issue(ALLOC, pg, 4'd0);
    chk({tag, " pending fail bit"}, allocResult, 8'h80);
    @(negedge clk);
    chk({tag, " granted number"}, allocResult, {4'h0, pkt});
    chk({tag, " irq"}, allocIrq, 1'b1);
  endtask

  task automatic allocPend(input logic [2:0] pg, input string tag);
    issue(ALLOC, pg, 4'd0);
    repeat (3) @(negedge clk);
    chk({tag, " stays pending"}, allocResult, 8'h80);
  endtask

  task automatic pulseTxDone(input logic ok);
    @(negedge clk); txDone = 1'b1; txOk = ok;
    @(negedge clk); txDone = 1'b0;
  endtask

  task automatic fillFull();
    allocGrant(3'd7, 4'd0, "fill");
    allocGrant(3'd7, 4'd1, "fill");
    allocGrant(3'd1, 4'd2, "fill");
  endtask

  task automatic t_reset_state();
    chk("R1 busy", busy, 1'b0);
    chk("R1 result", allocResult, 8'h80);
    chk("R1 irq", allocIrq, 1'b0);
    chk("R1 rx empty", rxEmpty, 1'b1);
    chk("R1 txq empty", txQEmpty, 1'b1);
    chk("R1 done empty", txDoneEmpty, 1'b1);
  endtask

  task automatic t_alloc_basic();
    wipe();
    allocGrant(3'd0, 4'd0, "R2 first");
    allocGrant(3'd1, 4'd1, "R2 second");
    ackIrq();
    chk("R11 ack clears", allocIrq, 1'b0);
  endtask

  task automatic t_contig_pending();
    wipe();
    allocGrant(3'd3, 4'd0, "R3 a");
    allocGrant(3'd3, 4'd1, "R3 b");
    allocGrant(3'd7, 4'd2, "R3 c");
    allocGrant(3'd1, 4'd3, "R3 d");
    freePkt(4'd0);
    freePkt(4'd3);
    allocPend(3'd4, "R3 five pages over split free runs");
    allocGrant(3'd3, 4'd0, "R4 overwrite with four pages");
    allocPend(3'd2, "R4 three pages");
    issue(FREE, 3'd0, 4'd1);
    chk("R4 still pending at free edge", allocResult, 8'h80);
    @(negedge clk);
    chk("R4 granted after free", allocResult, 8'h01);
    waitIdle();
  endtask

  task automatic t_busy();
    wipe();
    ackIrq();
    issue(RESET, 3'd0, 4'd0);
    chk("R5 busy cycle 1", busy, 1'b1);
    cmdValid = 1'b1; cmdOp = ALLOC; cmdPages = 3'd0;
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R5 busy cycle 2", busy, 1'b1);
    @(negedge clk);
    chk("R5 busy released", busy, 1'b0);
    repeat (3) @(negedge clk);
    chk("R5 alloc while busy ignored", allocResult, 8'h80);
    chk("R5 no irq from ignored alloc", allocIrq, 1'b0);
  endtask

  task automatic t_reset_cmd();
    wipe();
    fillFull();
    @(negedge clk); rxPush = 1'b1; rxPkt = 4'd1;
    @(negedge clk); rxPush = 1'b0;
    issue(ENQ, 3'd0, 4'd2);
    issue(ALLOC, 3'd0, 4'd0);
    issue(RESET, 3'd0, 4'd0);
    chk("R6 result", allocResult, 8'h80);
    chk("R6 irq", allocIrq, 1'b0);
    chk("R6 rx empty", rxEmpty, 1'b1);
    chk("R6 txq empty", txQEmpty, 1'b1);
    waitIdle();
    repeat (3) @(negedge clk);
    chk("R6 pending cancelled", allocResult, 8'h80);
    allocGrant(3'd7, 4'd0, "R6 pool freed");
    allocGrant(3'd7, 4'd1, "R6 pool freed");
  endtask

  task automatic t_free_invalid();
    wipe();
    fillFull();
    freePkt(4'd5);
    allocPend(3'd0, "R7 free of unused number");
    issue(FREE, 3'd0, 4'd2);
    @(negedge clk);
    chk("R7 freed packet regranted", allocResult, 8'h02);
    waitIdle();
  endtask

  task automatic t_tx();
    wipe();
    fillFull();
    autoRelease = 1'b0;
    issue(ENQ, 3'd0, 4'd2);
    issue(ENQ, 3'd0, 4'd0);
    chk("R8 head first enqueued", txQHead, 4'd2);
    pulseTxDone(1'b1);
    chk("R9 posted without auto", txDoneEmpty, 1'b0);
    chk("R9 posted number", txDoneHead, 4'd2);
    chk("R8 second in order", txQHead, 4'd0);
    autoRelease = 1'b1;
    pulseTxDone(1'b0);
    chk("R9 txq drained", txQEmpty, 1'b1);
    chk("R9 failed keeps order", txDoneHead, 4'd2);
    @(negedge clk); txDonePop = 1'b1;
    @(negedge clk); txDonePop = 1'b0;
    chk("R9 failed posted", txDoneHead, 4'd0);
    @(negedge clk); txDonePop = 1'b1;
    @(negedge clk); txDonePop = 1'b0;
    chk("R9 done drained", txDoneEmpty, 1'b1);
    allocPend(3'd0, "R9 reported packets keep pages");
    issue(ENQ, 3'd0, 4'd1);
    pulseTxDone(1'b1);
    chk("R9 auto release not posted", txDoneEmpty, 1'b1);
    chk("R9 grant follows release edge", allocResult, 8'h80);
    @(negedge clk);
    chk("R9 auto released pages", allocResult, 8'h01);
    autoRelease = 1'b0;
  endtask

  task automatic t_rx();
    wipe();
    fillFull();
    @(negedge clk); rxPush = 1'b1; rxPkt = 4'd1;
    @(negedge clk); rxPkt = 4'd2;
    @(negedge clk); rxPush = 1'b0;
    chk("R10 not empty", rxEmpty, 1'b0);
    chk("R10 head", rxHead, 4'd1);
    allocPend(3'd0, "R10 full pool");
    issue(RXREL, 3'd0, 4'd0);
    chk("R10 head advanced", rxHead, 4'd2);
    @(negedge clk);
    chk("R10 release freed pages", allocResult, 8'h01);
    waitIdle();
    issue(RXREL, 3'd0, 4'd0);
    chk("R10 drained", rxEmpty, 1'b1);
    waitIdle();
    allocGrant(3'd1, 4'd2, "R10 second release freed");
  endtask

  task automatic t_irq();
    wipe();
    allocGrant(3'd0, 4'd0, "R11 setup");
    allocGrant(3'd7, 4'd1, "R11 setup");
    allocGrant(3'd7, 4'd2, "R11 setup");
    allocGrant(3'd0, 4'd3, "R11 setup");
    ackIrq();
    chk("R11 acked", allocIrq, 1'b0);
    allocPend(3'd0, "R11 pending");
    issue(FREE, 3'd0, 4'd0);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
    chk("R11 grant beats ack", allocIrq, 1'b1);
    chk("R11 grant value", allocResult, 8'h00);
    @(negedge clk);
    chk("R11 sticky", allocIrq, 1'b1);
    waitIdle();
    ackIrq();
    chk("R11 ack clears", allocIrq, 1'b0);
  endtask

  task automatic t_same_cycle();
    wipe();
    fillFull();
    issue(ENQ, 3'd0, 4'd0);
    autoRelease = 1'b1;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = FREE; selPkt = 4'd2;
    txDone = 1'b1; txOk = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0; txDone = 1'b0;
    chk("R12 nothing posted", txDoneEmpty, 1'b1);
    chk("R12 txq drained", txQEmpty, 1'b1);
    waitIdle();
    allocGrant(3'd7, 4'd0, "R12 auto released run");
    allocGrant(3'd1, 4'd2, "R12 command freed run");
    autoRelease = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_alloc_basic();
    t_contig_pending();
    t_busy();
    t_reset_cmd();
    t_free_invalid();
    t_tx();
    t_rx();
    t_irq();
    t_same_cycle();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

endmodule